// File: doc/BRIEF.md
# AES-128 Round Key Generator

This block turns a 128-bit cipher key into the eleven 128-bit round keys that an AES-128 datapath needs. A one-cycle start pulse loads the cipher key as round key 0. After that, one further round key is computed and written on every clock. All eleven keys are kept in an internal register array.

A cipher core reads the keys combinationally through a 4-bit index port. An encryption engine walks the index upward from 0 to 10. A decryption engine walks it downward from 10 to 0. No keys are derived again for decryption. A ready flag tells the core when the whole array holds keys for the most recent accepted cipher key. A busy flag marks the ten cycles of generation.

Top module: `aes128_key_sched`

## Requirements
- R1: While reset is asserted and after it is released, ready_o and busy_o are 0 and every index reads as all zeros.
- R2: A start pulse accepted while the block is not generating writes the cipher key unchanged as round key 0. That key can be read at index 0 from the next cycle on.
- R3: busy_o is high for exactly 10 cycles after the start edge. ready_o rises exactly 10 clock edges after the start edge, and ready_o and busy_o are never high together.
- R4: Round key i is built from key i-1, whose word 0 is bits 127:96 and word 3 is bits 31:0. t = SubWord(RotWord(word3)) XOR (rcon_i << 24). new word0 = word0 XOR t, and each later new word is the old word XOR the new word before it.
- R5: The round constants for rounds 1 to 10 are 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 (each the previous one doubled in GF(2^8) modulo x^8+x^4+x^3+x+1). For the all-zero key, round key 1 is 62636363 repeated four times.
- R6: RotWord moves byte 31:24 of a word to byte 7:0, and the other bytes move up by one byte position.
- R7: For the cipher key 2b7e151628aed2a6abf7158809cf4f3c, round key 1 is a0fafe1788542cb123a339392a6c7605 and round key 10 is d014f9a8c9ee2589e13f0cc8b6630ca6.
- R8: rd_key_o shows the entry selected by rd_idx_i in the same cycle for indices 0 to 10. Indices 11 to 15 read as all zeros.
- R9: A start pulse while busy_o is high is ignored. Generation for the earlier key runs to completion unchanged.
- R10: A start pulse while ready_o is high restarts generation with the new key. ready_o drops at that edge and returns 10 edges later.
- R11: When the keys are read in ascending order, they encrypt plaintext 3243f6a8885a308d313198a2e0370734 to ciphertext 3925841d02dc09fbdc118597196a0b32. Reading them in descending order returns the same entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse that loads cipher_key_i |
| cipher_key_i | input | 128 | Cipher key, sampled when a start is accepted |
| rd_idx_i | input | 4 | Round key index for the read port |
| rd_key_o | output | 128 | Round key at rd_idx_i (zero when the index is above 10) |
| busy_o | output | 1 | Generation in progress |
| ready_o | output | 1 | All eleven round keys are valid |

## Verification
The bound assertions check the handshake on every cycle:
- busy and ready are mutually exclusive, and busy lasts ten cycles;
- ready rises only out of busy;
- a start that is accepted writes entry 0, and a start while busy never does;
- out-of-range indices read as zero;
- reset clears both flags.

Only the bench scenarios can show the key contents. The bench compares every readable entry each cycle against an independent expansion model. It also runs a full encryption of the known test block using the keys it reads back. Restart, ignored start and the zero-key and test-key vectors are driven as explicit scenarios.

// File: rtl/aks_pkg.sv
package aks_pkg;
  localparam int KEY_W      = 128;
  localparam int WORD_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int NUM_ROUNDS = 10;
  localparam int NUM_KEYS   = NUM_ROUNDS + 1;
  localparam int IDX_W      = $clog2(NUM_KEYS);
  localparam int NUM_WORDS  = KEY_W / WORD_W;
  localparam int WORD_BYTES = WORD_W / BYTE_W;
  localparam logic [BYTE_W-1:0] RCON_FIRST = 8'h01;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} aks_state_e;

  // multiply by x in GF(2^8), polynomial 0x11B
  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // forward substitution: field inverse (x^254) followed by the affine map
  function automatic logic [7:0] sbox_byte(input logic [7:0] x);
    logic [7:0] p, inv, b;
    p   = x;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p   = gf_mul(p, p);
      inv = gf_mul(inv, p);
    end
    b = inv;
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  // top byte goes to the bottom
  function automatic logic [WORD_W-1:0] rot_word(input logic [WORD_W-1:0] w);
    return {w[WORD_W-BYTE_W-1:0], w[WORD_W-1 -: BYTE_W]};
  endfunction
endpackage

// File: rtl/aks_subword.sv
module aks_subword
  import aks_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign word_o[g*BYTE_W +: BYTE_W] = sbox_byte(word_i[g*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/aks_round_step.sv
module aks_round_step
  import aks_pkg::*;
(
  input  logic [KEY_W-1:0]  prev_key_i,
  input  logic [BYTE_W-1:0] rcon_i,
  output logic [KEY_W-1:0]  next_key_o
);
  logic [WORD_W-1:0] prev_w [NUM_WORDS];
  logic [WORD_W-1:0] next_w [NUM_WORDS];
  logic [WORD_W-1:0] rotated, substituted, mix_word;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_split
    assign prev_w[g] = prev_key_i[KEY_W-1-g*WORD_W -: WORD_W];
    assign next_key_o[KEY_W-1-g*WORD_W -: WORD_W] = next_w[g];
  end

  assign rotated = rot_word(prev_w[NUM_WORDS-1]);

  aks_subword u_subword (
    .word_i (rotated),
    .word_o (substituted)
  );

  assign mix_word = substituted ^ {rcon_i, {(WORD_W-BYTE_W){1'b0}}};

  assign next_w[0] = prev_w[0] ^ mix_word;
  for (genvar g = 1; g < NUM_WORDS; g++) begin : g_chain
    assign next_w[g] = prev_w[g] ^ next_w[g-1];
  end
endmodule

// File: rtl/aks_key_store.sv
module aks_key_store #(
  parameter int DEPTH  = 11,
  parameter int DATA_W = 128,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       entry_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == ADDR_W'(g))       entry_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_i == ADDR_W'(i)) rd_data_o = entry_q[i];
    end
  end
endmodule

// File: rtl/aes128_key_sched.sv
module aes128_key_sched
  import aks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [KEY_W-1:0] cipher_key_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [KEY_W-1:0] rd_key_o,
  output logic             busy_o,
  output logic             ready_o
);
  aks_state_e        state_q;
  logic [KEY_W-1:0]  work_q, next_key;
  logic [IDX_W-1:0]  rnd_q;
  logic [BYTE_W-1:0] rcon_q;

  // named internal events
  logic              start_ok, running, last_step;
  logic              store_we;
  logic [IDX_W-1:0]  store_idx;
  logic [KEY_W-1:0]  store_data;

  assign running   = (state_q == ST_RUN);
  assign start_ok  = start_i && !running;
  assign last_step = running && (rnd_q == IDX_W'(NUM_ROUNDS));

  aks_round_step u_step (
    .prev_key_i (work_q),
    .rcon_i     (rcon_q),
    .next_key_o (next_key)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      work_q  <= '0;
      rnd_q   <= '0;
      rcon_q  <= RCON_FIRST;
    end else if (start_ok) begin
      state_q <= ST_RUN;
      work_q  <= cipher_key_i;
      rnd_q   <= IDX_W'(1);
      rcon_q  <= RCON_FIRST;
    end else if (running) begin
      work_q  <= next_key;
      rnd_q   <= rnd_q + IDX_W'(1);
      rcon_q  <= gf_xtime(rcon_q);
      if (last_step) state_q <= ST_DONE;
    end
  end

  assign store_we   = start_ok || running;
  assign store_idx  = start_ok ? '0 : rnd_q;
  assign store_data = start_ok ? cipher_key_i : next_key;

  aks_key_store #(
    .DEPTH  (NUM_KEYS),
    .DATA_W (KEY_W),
    .ADDR_W (IDX_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (store_we),
    .wr_idx_i  (store_idx),
    .wr_data_i (store_data),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_key_o)
  );

  assign busy_o  = running;
  assign ready_o = (state_q == ST_DONE);
endmodule

// File: rtl/aks_checker.sv
module aks_checker
  import aks_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic [KEY_W-1:0] rd_key_o,
  input logic             busy_o,
  input logic             ready_o,
  input logic             store_we,
  input logic [IDX_W-1:0] store_idx
);
  logic [IDX_W:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  p_reset_flags_r1: assert property (@(posedge clk) !rst_n |=> (!busy_o && !ready_o));

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && ready_o));

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_cnt == (IDX_W+1)'(NUM_ROUNDS)));

  p_ready_from_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(busy_o));

  p_load_slot0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |-> (store_we && store_idx == '0));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |-> (store_idx != '0));

  p_oob_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_i > IDX_W'(NUM_ROUNDS)) |-> (rd_key_o == '0));
endmodule

bind aes128_key_sched aks_checker u_aks_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .rd_idx_i  (rd_idx_i),
  .rd_key_o  (rd_key_o),
  .busy_o    (busy_o),
  .ready_o   (ready_o),
  .store_we  (store_we),
  .store_idx (store_idx)
);

// File: tb/test_aes128_key_sched.sv
`timescale 1ns/1ps
module test_aes128_key_sched;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] cipher_key_i = '0;
  logic [3:0]   rd_idx_i = '0;
  logic [127:0] rd_key_o;
  logic         busy_o, ready_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  aes128_key_sched i_aes128_key_sched (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cipher_key_i(cipher_key_i),
    .rd_idx_i(rd_idx_i), .rd_key_o(rd_key_o), .busy_o(busy_o), .ready_o(ready_o)
  );

  // ---------------- independent reference ----------------
  logic [7:0] sb [256];

  initial begin
    int p, q, x;
    p = 1; q = 1;
    do begin
      p = (p ^ (p << 1) ^ ((p & 8'h80) != 0 ? 8'h1B : 0)) & 8'hFF;
      q = q ^ (q << 1); q = q ^ (q << 2); q = q ^ (q << 4); q = q & 8'hFF;
      if ((q & 8'h80) != 0) q = q ^ 8'h09;
      x = q ^ (((q << 1) | (q >> 7)) & 8'hFF) ^ (((q << 2) | (q >> 6)) & 8'hFF)
            ^ (((q << 3) | (q >> 5)) & 8'hFF) ^ (((q << 4) | (q >> 4)) & 8'hFF);
      sb[p] = 8'((x ^ 8'h63) & 8'hFF);
    end while (p != 1);
    sb[0] = 8'h63;
  end

  function automatic logic [7:0] rc_of(int r);
    int v = 1;
    for (int i = 1; i < r; i++) begin
      v = v << 1;
      if (v > 255) v = (v ^ 9'h11B);
    end
    return 8'(v);
  endfunction

  function automatic logic [127:0] ref_next(logic [127:0] k, int r);
    logic [31:0] w [4];
    logic [31:0] t;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    t = {w[3][23:0], w[3][31:24]};
    t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
    t[31:24] = t[31:24] ^ rc_of(r);
    w[0] = w[0] ^ t;
    for (int i = 1; i < 4; i++) w[i] = w[i] ^ w[i-1];
    return {w[0], w[1], w[2], w[3]};
  endfunction

  function automatic logic [7:0] xt(logic [7:0] a);
    return (a << 1) ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [127:0] encrypt(logic [127:0] pt, logic [127:0] ks [11]);
    logic [7:0] s [16];
    logic [7:0] u [16];
    logic [127:0] v;
    v = pt ^ ks[0];
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) s[i] = sb[v[127-8*i -: 8]];
      for (int c = 0; c < 4; c++)
        for (int rw = 0; rw < 4; rw++) u[4*c+rw] = s[4*((c+rw)%4)+rw];
      if (r < 10) begin
        for (int c = 0; c < 4; c++) begin
          s[4*c]   = xt(u[4*c]) ^ xt(u[4*c+1]) ^ u[4*c+1] ^ u[4*c+2] ^ u[4*c+3];
          s[4*c+1] = u[4*c] ^ xt(u[4*c+1]) ^ xt(u[4*c+2]) ^ u[4*c+2] ^ u[4*c+3];
          s[4*c+2] = u[4*c] ^ u[4*c+1] ^ xt(u[4*c+2]) ^ xt(u[4*c+3]) ^ u[4*c+3];
          s[4*c+3] = xt(u[4*c]) ^ u[4*c] ^ u[4*c+1] ^ u[4*c+2] ^ xt(u[4*c+3]);
        end
      end else begin
        for (int i = 0; i < 16; i++) s[i] = u[i];
      end
      for (int i = 0; i < 16; i++) v[127-8*i -: 8] = s[i];
      v = v ^ ks[r];
    end
    return v;
  endfunction

  // cycle model
  logic [127:0] m_key [11];
  logic [127:0] m_work;
  int m_rnd;
  bit m_busy, m_ready;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 11; i++) m_key[i] <= '0;
      m_busy <= 0; m_ready <= 0; m_rnd <= 0; m_work <= '0;
    end else if (start_i && !m_busy) begin
      m_key[0] <= cipher_key_i; m_work <= cipher_key_i;
      m_busy <= 1; m_ready <= 0; m_rnd <= 1;
    end else if (m_busy) begin
      m_key[m_rnd] <= ref_next(m_work, m_rnd);
      m_work <= ref_next(m_work, m_rnd);
      m_rnd <= m_rnd + 1;
      if (m_rnd == 10) begin m_busy <= 0; m_ready <= 1; end
    end
  end

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison, away from the rising edge (R3, R4, R5, R8)
  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk(busy_o == m_busy, "R3 busy", 128'(busy_o), 128'(m_busy));
      chk(ready_o == m_ready, "R3 ready", 128'(ready_o), 128'(m_ready));
      chk(rd_key_o == ((rd_idx_i <= 10) ? m_key[rd_idx_i] : 128'h0), "R4 R5 R8 key read",
          rd_key_o, (rd_idx_i <= 10) ? m_key[rd_idx_i] : 128'h0);
    end
  end

  task automatic read_at(int idx, output logic [127:0] k);
    @(negedge clk); rd_idx_i = 4'(idx); #1; k = rd_key_o;
  endtask

  task automatic start_and_wait(logic [127:0] key, output int edges);
    @(negedge clk); cipher_key_i = key; start_i = 1;
    edges = 0;
    do begin
      @(negedge clk); start_i = 0; #1; edges++;
    end while (!ready_o && edges < 30);
  endtask

  localparam logic [127:0] TKEY = 128'h2b7e151628aed2a6abf7158809cf4f3c;

  initial begin
    logic [127:0] k, asc [11];
    int edges;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!busy_o && !ready_o, "R1 flags in reset", 128'({busy_o, ready_o}), 128'h0);
    rst_n = 1;
    read_at(0, k);  chk(k == 0, "R1 idx0 zero", k, 0);
    read_at(10, k); chk(k == 0, "R1 idx10 zero", k, 0);
    chk(!busy_o && !ready_o, "R1 flags after reset", 128'({busy_o, ready_o}), 128'h0);

    // R2, R3, R7 on the test key
    @(negedge clk); rd_idx_i = 0; cipher_key_i = TKEY; start_i = 1;
    @(negedge clk); start_i = 0; #1;
    chk(rd_key_o == TKEY, "R2 round key 0 is cipher key", rd_key_o, TKEY);
    chk(busy_o, "R3 busy after start", 128'(busy_o), 128'h1);
    edges = 1;
    while (!ready_o && edges < 30) begin @(negedge clk); #1; edges++; end
    chk(edges == 11, "R3 ready 10 edges after start edge", 128'(edges - 1), 128'd10);
    read_at(1, k);
    chk(k == 128'ha0fafe1788542cb123a339392a6c7605, "R6 R7 round key 1", k,
        128'ha0fafe1788542cb123a339392a6c7605);
    read_at(10, k);
    chk(k == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R7 round key 10", k,
        128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

    // R11 ascending use for encryption, descending read matches
    for (int i = 0; i < 11; i++) read_at(i, asc[i]);
    k = encrypt(128'h3243f6a8885a308d313198a2e0370734, asc);
    chk(k == 128'h3925841d02dc09fbdc118597196a0b32, "R11 encryption", k,
        128'h3925841d02dc09fbdc118597196a0b32);
    for (int i = 10; i >= 0; i--) begin
      read_at(i, k);
      chk(k == asc[i], "R11 descending read", k, asc[i]);
    end

    // R8 out-of-range indices
    for (int i = 11; i < 16; i++) begin
      read_at(i, k);
      chk(k == 0, "R8 index above 10 reads zero", k, 0);
    end

    // R10 restart from ready with the zero key; R5 zero-key round 1
    @(negedge clk); rd_idx_i = 1; cipher_key_i = '0; start_i = 1;
    @(negedge clk); start_i = 0; #1;
    chk(!ready_o, "R10 ready drops on restart", 128'(ready_o), 128'h0);
    repeat (11) @(negedge clk);
    #1;
    chk(ready_o, "R10 ready returns", 128'(ready_o), 128'h1);
    read_at(1, k);
    chk(k == 128'h62636363626363636263636362636363, "R5 zero key round 1", k,
        128'h62636363626363636263636362636363);

    // R9 start while busy ignored
    @(negedge clk); rd_idx_i = 0; cipher_key_i = TKEY; start_i = 1;
    @(negedge clk); start_i = 0;
    repeat (3) @(negedge clk);
    cipher_key_i = 128'h00112233445566778899aabbccddeeff; start_i = 1;
    @(negedge clk); start_i = 0; #1;
    chk(rd_key_o == TKEY, "R9 round key 0 kept", rd_key_o, TKEY);
    while (!ready_o) @(negedge clk);
    #1;
    read_at(10, k);
    chk(k == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R9 schedule unchanged", k,
        128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

    // R4 random keys against the model (per-cycle compare plus final read)
    for (int n = 0; n < 6; n++) begin
      logic [127:0] rk, e;
      rk = {$urandom, $urandom, $urandom, $urandom};
      start_and_wait(rk, edges);
      e = rk;
      for (int r = 1; r <= 10; r++) e = ref_next(e, r);
      read_at(10, k);
      chk(k == e, "R4 random key round 10", k, e);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    done = 1;
    $display("FAIL watchdog actual=%h expected=%h", 128'h1, 128'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule